// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block takes bytes from a serial data line whose bit timing comes from a serial clock driven by the far end. Both lines are asynchronous to the fast system clock, so they pass through a synchronizer first. The receiver then finds the trailing edge of the serial clock and samples the data line on that edge. A frame is built from a low start bit, a byte of data sent least significant bit first, and a high stop bit. Once the frame is complete, the byte is moved into a data register, the status is updated and an interrupt is raised.

The shift logic accepts a new edge only after a fixed minimum number of system clocks has passed since the last accepted shift. Edges that arrive sooner are dropped. After the stop bit, a short transfer window follows, and edges in that window are dropped too. If a bit is lost, the receiver stays out of step in a way that can be predicted: the start bit of the next frame is read as the stop bit, which sets a sticky framing error, and the frame after that is skipped. Software reads the byte, acknowledges the interrupt and clears the sticky status through plain strobe inputs.

Top module: `sclk_rx_top`

## Requirements
- R1: After reset the data register reads 0, and `irq_o`, `ferr_o` and `ovr_o` are all 0.
- R2: Data is sampled on each accepted falling edge of the serial clock. The first bit after the start bit lands in bit 0 of `rx_data_o`. Any payload is valid, 0xFF included. `rx_data_o` changes only when a frame completes.
- R3: While idle, the receiver treats every accepted edge with the data line at 1 as no frame. A frame begins only on an accepted edge that samples 0.
- R4: A serial clock falling edge that comes fewer than MIN_GAP (3) system clocks after the last accepted shift is lost. An edge that comes exactly MIN_GAP clocks after it is accepted.
- R5: The interrupt is raised exactly SYNC_STAGES+1+XFER_LAT system clocks after `ser_clk_i` falls on the stop bit (7 with the bench's parameters).
- R6: If the stop bit samples 0, the byte is still loaded and `ferr_o` is set. If a data bit is lost, the next frame's start bit is taken as the stop bit, so `ferr_o` is set and the frame that follows is skipped.
- R7: `ferr_o` and `ovr_o` stay set until `stat_clr_i` is pulsed. Further good frames do not clear them.
- R8: If a byte completes while the previous byte is still unread, `ovr_o` is set and the new byte replaces the old one. A `rd_stb_i` pulse marks the byte as read.
- R9: An edge that comes within the XFER_LAT clocks after the stop bit was accepted is lost, even if it carries a start bit.
- R10: `irq_o` is the pending flag gated by `irq_en_i`. A pending interrupt survives while `irq_en_i` is low. An `irq_ack_i` pulse clears the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | External serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| rd_stb_i | input | 1 | Marks the data register as read |
| irq_en_i | input | 1 | Interrupt enable level |
| irq_ack_i | input | 1 | Clears the pending interrupt |
| stat_clr_i | input | 1 | Clears the sticky framing and overrun flags |
| rx_data_o | output | DATA_W | Last received byte |
| irq_o | output | 1 | Interrupt request |
| ferr_o | output | 1 | Sticky framing error |
| ovr_o | output | 1 | Sticky overrun |

## Verification
The bench builds the receiver with an 8-bit byte, a two-stage synchronizer, a minimum shift spacing of 3 and a transfer window of 4. The wider transfer window lets a start bit placed 3 clocks after the stop bit satisfy the spacing rule but still fall inside the window, so the loss described in R9 can be seen apart from the loss described in R4. With these small values, spacings of exactly 2 and 3 clocks can be driven with one-cycle clock pulses, and the exact interrupt latency of 7 cycles can be checked cycle by cycle.

// File: rtl/sclk_rx_pkg.sv
package sclk_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_STOP = 2'd2,
      ST_XFER = 2'd3
   } rx_state_t;
endpackage

// File: rtl/sclk_rx_sync.sv
module sclk_rx_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sclk_rx_pace.sv
module sclk_rx_pace #(
   parameter int MIN_GAP    = 3,
   parameter bit TRAIL_FALL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sclk_i,
   output logic shift_o
);
   localparam int GW = $clog2(MIN_GAP + 1);
   localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);

   logic          sclk_q;
   logic          edge_w;
   logic          gap_ok;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sclk_q <= 1'b1;
      else         sclk_q <= sclk_i;
   end

   if (TRAIL_FALL) begin : g_fall
      assign edge_w = sclk_q & ~sclk_i;
   end else begin : g_rise
      assign edge_w = ~sclk_q & sclk_i;
   end

   assign gap_ok  = (gap_q == GAP_MAX);
   assign shift_o = edge_w & gap_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      gap_q <= GAP_MAX;
      else if (shift_o) gap_q <= GW'(1);
      else if (!gap_ok) gap_q <= gap_q + GW'(1);
   end
endmodule

// File: rtl/sclk_rx_frame.sv
module sclk_rx_frame
   import sclk_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int XFER_LAT  = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic              sdat_i,
   output logic              done_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              stop_o
);
   localparam int CW = $clog2(DATA_W);
   localparam int XW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1;
   localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);
   localparam logic [XW-1:0] LAST_X   = XW'(XFER_LAT - 1);

   rx_state_t         state_q;
   logic [CW-1:0]     cnt_q;
   logic [XW-1:0]     xc_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_nx;
   logic              stop_q;

   if (LSB_FIRST) begin : g_lsb
      assign sh_nx = {sdat_i, sh_q[DATA_W-1:1]};
   end else begin : g_msb
      assign sh_nx = {sh_q[DATA_W-2:0], sdat_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         xc_q    <= '0;
         sh_q    <= '0;
         stop_q  <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: if (shift_i && !sdat_i) begin
               state_q <= ST_DATA;
               cnt_q   <= '0;
            end
            ST_DATA: if (shift_i) begin
               sh_q  <= sh_nx;
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == LAST_BIT) state_q <= ST_STOP;
            end
            ST_STOP: if (shift_i) begin
               stop_q  <= sdat_i;
               xc_q    <= '0;
               state_q <= ST_XFER;
            end
            ST_XFER: begin
               xc_q <= xc_q + XW'(1);
               if (xc_q == LAST_X) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o = (state_q == ST_XFER) && (xc_q == LAST_X);
   assign byte_o = sh_q;
   assign stop_o = stop_q;
endmodule

// File: rtl/sclk_rx_top.sv
module sclk_rx_top #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_GAP     = 3,
   parameter int XFER_LAT    = 4,
   parameter bit TRAIL_FALL  = 1'b1,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              rd_stb_i,
   input  logic              irq_en_i,
   input  logic              irq_ack_i,
   input  logic              stat_clr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              irq_o,
   output logic              ferr_o,
   output logic              ovr_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sclk_rx_top: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sclk_rx_top: SYNC_STAGES must be at least 2");
   end
   if (MIN_GAP < 1) begin : g_bad_gap
      $error("sclk_rx_top: MIN_GAP must be at least 1");
   end
   if (XFER_LAT < 1) begin : g_bad_xfer
      $error("sclk_rx_top: XFER_LAT must be at least 1");
   end

   logic [1:0]        sync_w;
   logic              shift_w;
   logic              done_w;
   logic              stop_w;
   logic [DATA_W-1:0] byte_w;
   logic              full_q;
   logic              pend_q;

   sclk_rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({ser_clk_i, ser_dat_i}),
      .q_o   (sync_w)
   );

   sclk_rx_pace #(.MIN_GAP(MIN_GAP), .TRAIL_FALL(TRAIL_FALL)) pace_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sclk_i (sync_w[1]),
      .shift_o(shift_w)
   );

   sclk_rx_frame #(.DATA_W(DATA_W), .XFER_LAT(XFER_LAT), .LSB_FIRST(LSB_FIRST)) frame_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_w),
      .sdat_i (sync_w[0]),
      .done_o (done_w),
      .byte_o (byte_w),
      .stop_o (stop_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rx_data_o <= '0;
      else if (done_w) rx_data_o <= byte_w;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       full_q <= 1'b0;
      else if (done_w)   full_q <= 1'b1;
      else if (rd_stb_i) full_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ovr_o <= 1'b0;
      else if (done_w && full_q && !rd_stb_i) ovr_o <= 1'b1;
      else if (stat_clr_i)                  ovr_o <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ferr_o <= 1'b0;
      else if (done_w && !stop_w) ferr_o <= 1'b1;
      else if (stat_clr_i)        ferr_o <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (done_w)    pend_q <= 1'b1;
      else if (irq_ack_i) pend_q <= 1'b0;
   end

   assign irq_o = pend_q & irq_en_i;
endmodule

// File: rtl/sclk_rx_chk.sv
module sclk_rx_chk #(
   parameter int DATA_W  = 8,
   parameter int MIN_GAP = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              shift_i,
   input logic              done_i,
   input logic [DATA_W-1:0] rdata_i,
   input logic              ferr_i,
   input logic              ovr_i,
   input logic              clr_i,
   input logic              pend_i
);
   localparam int GW = $clog2(MIN_GAP + 1);
   localparam logic [GW-1:0] SAT = GW'(MIN_GAP);

   logic [GW-1:0] since_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           since_q <= SAT;
      else if (shift_i)      since_q <= GW'(1);
      else if (since_q != SAT) since_q <= since_q + GW'(1);
   end

   assert_min_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |-> (since_q == SAT));

   assert_data_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |=> $stable(rdata_i));

   assert_ferr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ferr_i && !clr_i) |=> ferr_i);

   assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_i && !clr_i) |=> ovr_i);

   assert_pend_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i) |-> $past(done_i));
endmodule

bind sclk_rx_top sclk_rx_chk #(.DATA_W(DATA_W), .MIN_GAP(MIN_GAP)) chk_i (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .shift_i(shift_w),
   .done_i (done_w),
   .rdata_i(rx_data_o),
   .ferr_i (ferr_o),
   .ovr_i  (ovr_o),
   .clr_i  (stat_clr_i),
   .pend_i (pend_q)
);

// File: tb/sclk_rx_top_tb.sv
module sclk_rx_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 2 + 1 + 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b1;
   logic       sdat = 1'b1;
   logic       rd = 1'b0;
   logic       en = 1'b1;
   logic       ack = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] rdata;
   logic       irq, ferr, ovr;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sclk_rx_top #(.DATA_W(8), .SYNC_STAGES(2), .MIN_GAP(3), .XFER_LAT(4)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
      .rd_stb_i(rd), .irq_en_i(en), .irq_ack_i(ack), .stat_clr_i(clr),
      .rx_data_o(rdata), .irq_o(irq), .ferr_o(ferr), .ovr_o(ovr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      sclk = 1'b1; sdat = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int hi, input int lo);
      sdat = b; sclk = 1'b1;
      repeat (hi) @(negedge clk);
      sclk = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic send_data(input logic [7:0] d, input int hi, input int lo);
      for (int i = 0; i < 8; i++) send_bit(d[i], hi, lo);
   endtask

   task automatic send_frame(input logic [7:0] d, input int hi, input int lo, input logic stopb);
      send_bit(1'b0, hi, lo);
      send_data(d, hi, lo);
      send_bit(stopb, hi, lo);
      idle(12);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; @(negedge clk); s = 1'b0;
   endtask

   task automatic tidy();
      pulse(rd); pulse(ack); pulse(clr);
   endtask

   task automatic t_reset();
      chk("R1", "rx_data", rdata, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "ferr", ferr, 0);
      chk("R1", "ovr", ovr, 0);
   endtask

   task automatic t_basic();
      send_frame(8'hA5, 3, 3, 1'b1);
      chk("R2", "rx_data A5", rdata, 8'hA5);
      chk("R10", "irq raised", irq, 1);
      chk("R2", "ferr clean", ferr, 0);
      pulse(ack);
      chk("R10", "irq after ack", irq, 0);
      pulse(rd);
      send_frame(8'hFF, 3, 3, 1'b1);
      chk("R2", "rx_data FF", rdata, 8'hFF);
      tidy();
   endtask

   task automatic t_latency();
      send_bit(1'b0, 3, 3);
      send_data(8'h6C, 3, 3);
      sdat = 1'b1; sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk("R5", "irq one cycle early", irq, 0);
      @(negedge clk);
      chk("R5", "irq at latency", irq, 1);
      idle(10);
      chk("R5", "rx_data 6C", rdata, 8'h6C);
      tidy();
   endtask

   task automatic t_wait_start();
      for (int i = 0; i < 5; i++) send_bit(1'b1, 3, 3);
      idle(4);
      chk("R3", "no frame from ones", irq, 0);
      send_frame(8'h3C, 3, 3, 1'b1);
      chk("R3", "rx_data 3C", rdata, 8'h3C);
      chk("R3", "ferr clean", ferr, 0);
      tidy();
   endtask

   task automatic t_gap();
      send_frame(8'h96, 2, 1, 1'b1);
      chk("R4", "rx_data at exact gap", rdata, 8'h96);
      chk("R4", "ferr at exact gap", ferr, 0);
      tidy();
      send_bit(1'b0, 3, 3);
      send_bit(1'b0, 3, 3);
      send_bit(1'b1, 3, 3);
      send_bit(1'b0, 3, 1);
      send_bit(1'b1, 1, 3);
      send_bit(1'b1, 3, 3);
      send_bit(1'b0, 3, 3);
      send_bit(1'b1, 3, 3);
      send_bit(1'b0, 3, 3);
      send_bit(1'b1, 3, 3);
      send_frame(8'hFF, 3, 3, 1'b1);
      chk("R4", "shifted byte", rdata, 8'hAA);
      chk("R6", "ferr after lost bit", ferr, 1);
      send_frame(8'h3C, 3, 3, 1'b1);
      chk("R6", "frame after skip", rdata, 8'h3C);
      chk("R7", "ferr still set", ferr, 1);
      pulse(clr);
      chk("R7", "ferr cleared", ferr, 0);
      tidy();
   endtask

   task automatic t_stop0();
      send_frame(8'h81, 3, 3, 1'b0);
      chk("R6", "byte loaded on bad stop", rdata, 8'h81);
      chk("R6", "ferr on bad stop", ferr, 1);
      tidy();
   endtask

   task automatic t_ovr();
      send_frame(8'h11, 3, 3, 1'b1);
      chk("R8", "no overrun first", ovr, 0);
      send_frame(8'h22, 3, 3, 1'b1);
      chk("R8", "overrun set", ovr, 1);
      chk("R8", "newer byte kept", rdata, 8'h22);
      send_frame(8'h23, 3, 3, 1'b1);
      chk("R7", "ovr sticky", ovr, 1);
      pulse(clr);
      pulse(rd);
      send_frame(8'h33, 3, 3, 1'b1);
      chk("R8", "no overrun after read", ovr, 0);
      tidy();
   endtask

   task automatic t_xfer();
      send_bit(1'b0, 3, 3);
      send_data(8'h44, 3, 3);
      send_bit(1'b1, 3, 1);
      send_bit(1'b0, 2, 3);
      send_data(8'hFF, 3, 3);
      send_bit(1'b1, 3, 3);
      idle(12);
      chk("R9", "start in window lost", rdata, 8'h44);
      chk("R9", "no framing error", ferr, 0);
      tidy();
      send_frame(8'h3C, 3, 3, 1'b1);
      chk("R9", "next frame ok", rdata, 8'h3C);
      tidy();
   endtask

   task automatic t_irq();
      en = 1'b0;
      send_frame(8'h55, 3, 3, 1'b1);
      chk("R10", "irq masked", irq, 0);
      en = 1'b1;
      @(negedge clk);
      chk("R10", "pending shows on enable", irq, 1);
      pulse(ack);
      chk("R10", "irq cleared by ack", irq, 0);
      idle(3);
      chk("R10", "irq stays clear", irq, 0);
      tidy();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_latency();
      t_wait_start();
      t_gap();
      t_stop0();
      t_ovr();
      t_xfer();
      t_irq();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule